// File: doc/BRIEF.md
# Shared-Line Interrupt Request Controller

This block merges many device interrupt request lines into one maskable processor interrupt. Device lines are grouped into channels: each channel sees the logical OR of its group, so several devices can share one channel. A per-channel mask bit blocks the channel's request before it reaches the channel's request latch. Each channel can be set to edge mode, which captures a rising edge and holds it, or to level mode, which tracks a request that stays high. The processor interrupt is high whenever any latch holds a request.

Software uses a small write port with three registers: the mask, the per-channel mode and an end-of-interrupt command. A command can name a channel, or it can clear the pending channel with the highest priority. The latch states can be read at all times on a status output. Because the mask acts ahead of edge detection, clearing the mask of a channel whose shared input is still high produces a new edge.

Top module: `shirq_ctrl`

## Requirements
- R1: A channel's raw request is the OR of its device lines. Channel c owns devReq[c*LINES_PER_CH +: LINES_PER_CH]. While one line in the group stays high, a second line in the group that rises makes no new edge.
- R2: The gated request is the raw request with the channel's mask bit applied. A masked channel can never set its latch.
- R3: cpuIrq is high exactly when at least one bit of pendStatus is set. Bit c of pendStatus is channel c's latch.
- R4: In edge mode a 0-to-1 change of the gated request sets the latch at the next clock edge. The latch stays set after the request falls, so a pulse lasting one cycle is captured.
- R5: In edge mode an end-of-interrupt for the channel clears the latch even when the request is still high. The latch does not set again until a new rising edge arrives.
- R6: In level mode the latch is set while the gated request is high. An end-of-interrupt clears it only when the gated request is low; otherwise the latch stays set.
- R7: Register writes take effect at the clock edge where wrEn is high. Address 0 is the mask register, where bit c = 1 masks channel c. Address 1 is the mode register, where bit c = 1 puts channel c in level mode.
- R8: A write to address 2 is an end-of-interrupt command. When bit 7 is 0, it is specific and clears the channel numbered by bits 6:0.
- R9: When bit 7 of the command is 1, the command is non-specific. It clears only the lowest-numbered channel whose latch is set, because a lower index means higher priority.
- R10: In edge mode, unmasking a channel whose input is held high produces a new rising edge, and the latch sets again.
- R11: If a set condition and a clear command reach the same channel in the same cycle, the latch ends up set.
- R12: After reset all latches are clear, every channel is masked and every channel is in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| devReq | input | NUM_CH*LINES_PER_CH | Device request lines, grouped by channel |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 mask, 1 mode, 2 command |
| wrData | input | 8 | Register write data |
| pendStatus | output | NUM_CH | Latch state of every channel |
| cpuIrq | output | 1 | Processor interrupt request |

## Verification
The checker checks four things on every cycle:
- A masked channel never moves from clear to set.
- An edge-mode latch holds when no clear reaches it.
- A level-mode latch holds while its request stays high.
- At most one channel is cleared at a time, and a clear without a coinciding edge empties an edge-mode latch.

Some behaviours need a particular sequence of writes and line activity, so only the bench scenarios show them:
- the priority choice of a non-specific command;
- the new edge after unmasking;
- capture of a pulse one cycle long;
- the lack of a new edge when a second shared line rises.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
  localparam int REG_W       = 8;
  localparam int ADDR_W      = 2;
  localparam int CMD_NS_BIT  = 7;
  localparam int CMD_CH_W    = 7;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd2;

  // strobes from the register control to the datapath
  typedef struct packed {
    logic                eoiValid;
    logic                eoiNonSpec;
    logic [CMD_CH_W-1:0] eoiCh;
  } eoiStrobe_t;
endpackage

// File: rtl/shirq_ctrl_regs.sv
module shirq_ctrl_regs
  import shirq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  output logic [NUM_CH-1:0] maskReg,
  output logic [NUM_CH-1:0] modeReg,
  output eoiStrobe_t        strobe
);
  logic maskWe, modeWe;

  always_comb begin
    maskWe            = wrEn && (wrAddr == ADDR_MASK);
    modeWe            = wrEn && (wrAddr == ADDR_MODE);
    strobe.eoiValid   = wrEn && (wrAddr == ADDR_CMD);
    strobe.eoiNonSpec = wrData[CMD_NS_BIT];
    strobe.eoiCh      = wrData[CMD_CH_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '1;
      modeReg <= '0;
    end else begin
      if (maskWe) maskReg <= wrData[NUM_CH-1:0];
      if (modeWe) modeReg <= wrData[NUM_CH-1:0];
    end
  end
endmodule

// File: rtl/shirq_datapath.sv
module shirq_datapath
  import shirq_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int LINES_PER_CH = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_CH*LINES_PER_CH-1:0] devReq,
  input  logic [NUM_CH-1:0]              maskReg,
  input  logic [NUM_CH-1:0]              modeReg,
  input  eoiStrobe_t                     strobe,
  output logic [NUM_CH-1:0]              pend,
  output logic [NUM_CH-1:0]              gatedVec,
  output logic [NUM_CH-1:0]              riseVec,
  output logic [NUM_CH-1:0]              clrVec
);
  logic [NUM_CH-1:0] prevGated;
  logic [NUM_CH-1:0] lowestPend;
  logic [NUM_CH-1:0] specDec;
  logic [NUM_CH-1:0] setVec;

  // isolate the lowest set latch: highest priority
  assign lowestPend = pend & (~pend + 1'b1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic rawReq;
    assign rawReq      = |devReq[c*LINES_PER_CH +: LINES_PER_CH];
    assign gatedVec[c] = rawReq & ~maskReg[c];
    assign riseVec[c]  = gatedVec[c] & ~prevGated[c];
    assign setVec[c]   = modeReg[c] ? gatedVec[c] : riseVec[c];
    assign specDec[c]  = (strobe.eoiCh == CMD_CH_W'(c));
  end

  always_comb begin
    if (!strobe.eoiValid)      clrVec = '0;
    else if (strobe.eoiNonSpec) clrVec = lowestPend;
    else                        clrVec = specDec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevGated <= '0;
      pend      <= '0;
    end else begin
      prevGated <= gatedVec;
      pend      <= setVec | (pend & ~clrVec);
    end
  end
endmodule

// File: rtl/shirq_ctrl.sv
module shirq_ctrl
  import shirq_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int LINES_PER_CH = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_CH*LINES_PER_CH-1:0] devReq,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [REG_W-1:0]               wrData,
  output logic [NUM_CH-1:0]              pendStatus,
  output logic                           cpuIrq
);
  logic [NUM_CH-1:0] maskReg, modeReg, gatedVec, riseVec, clrVec;
  eoiStrobe_t strobe;

  shirq_ctrl_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .maskReg(maskReg), .modeReg(modeReg), .strobe(strobe)
  );

  shirq_datapath #(.NUM_CH(NUM_CH), .LINES_PER_CH(LINES_PER_CH)) u_dp (
    .clk(clk), .rstN(rstN), .devReq(devReq), .maskReg(maskReg),
    .modeReg(modeReg), .strobe(strobe), .pend(pendStatus),
    .gatedVec(gatedVec), .riseVec(riseVec), .clrVec(clrVec)
  );

  assign cpuIrq = |pendStatus;
endmodule

// File: rtl/shirq_ctrl_chk.sv
module shirq_ctrl_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] pendStatus,
  input logic [NUM_CH-1:0] maskReg,
  input logic [NUM_CH-1:0] modeReg,
  input logic [NUM_CH-1:0] gatedVec,
  input logic [NUM_CH-1:0] riseVec,
  input logic [NUM_CH-1:0] clrVec
);
  a_r9_single_clear: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clrVec));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    a_r2_masked_no_set: assert property (@(posedge clk) disable iff (!rstN)
      ($past(maskReg[c]) && !$past(pendStatus[c])) |-> !pendStatus[c]);

    a_r4_edge_hold: assert property (@(posedge clk) disable iff (!rstN)
      $past(pendStatus[c] && !modeReg[c] && !clrVec[c]) |-> pendStatus[c]);

    a_r5_edge_clear: assert property (@(posedge clk) disable iff (!rstN)
      $past(clrVec[c] && !modeReg[c] && !riseVec[c]) |-> !pendStatus[c]);

    a_r6_level_hold: assert property (@(posedge clk) disable iff (!rstN)
      $past(pendStatus[c] && modeReg[c] && gatedVec[c]) |-> pendStatus[c]);
  end
endmodule

bind shirq_ctrl shirq_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .pendStatus(pendStatus), .maskReg(maskReg),
  .modeReg(modeReg), .gatedVec(gatedVec), .riseVec(riseVec), .clrVec(clrVec)
);

// File: tb/shirq_ctrl_test.sv
module shirq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int NL  = 3;

  logic clk = 0;
  logic rstN = 0;
  logic [NCH*NL-1:0] devReq = '0;
  logic wrEn = 0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [NCH-1:0] pendStatus;
  logic cpuIrq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [NCH-1:0] pend;
    string          req;
  } expItem_t;
  expItem_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  shirq_ctrl #(.NUM_CH(NCH), .LINES_PER_CH(NL)) uut (
    .clk(clk), .rstN(rstN), .devReq(devReq), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pendStatus(pendStatus), .cpuIrq(cpuIrq)
  );

  task automatic compare(input logic [NCH-1:0] exp, input string req);
    checks++;
    if (pendStatus !== exp || cpuIrq !== (|exp)) begin
      failures++;
      $display("FAIL %s: pend=%b irq=%b expected pend=%b irq=%b",
               req, pendStatus, cpuIrq, exp, |exp);
    end
  endtask

  // monitor: compares one expected item per falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      expItem_t it;
      it = sb.pop_front();
      compare(it.pend, it.req);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
  endtask

  // driver: expected state after the coming rising edge
  task automatic tick(input logic [NCH-1:0] exp, input string req);
    #1;
    sb.push_back('{exp, req});
    @(negedge clk);
    wrEn = 0;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    failures++;
    $display("FAIL watchdog: hung run, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(4'b0000, "R12 reset");
    rstN = 1;
    // R12/R2: masked after reset, request ignored
    devReq[1] = 1;
    tick(4'b0000, "R2 masked");
    tick(4'b0000, "R12 masked default");
    // R7: unmask takes effect at write edge, edge seen next cycle
    wr(2'd0, 8'h00);
    tick(4'b0000, "R7 mask write");
    tick(4'b0001, "R4 edge sets");
    devReq[1] = 0;
    tick(4'b0001, "R4 edge hold");
    devReq[8] = 1;
    tick(4'b0101, "R4 pulse captured");
    devReq[8] = 0;
    tick(4'b0101, "R4 pulse held");
    // R9: non-specific clears lowest first
    wr(2'd2, 8'h80);
    tick(4'b0100, "R9 nonspec lowest");
    wr(2'd2, 8'h80);
    tick(4'b0000, "R9 nonspec next");
    // R5/R8: specific clear with input high
    devReq[3] = 1;
    tick(4'b0010, "R4 ch1 edge");
    wr(2'd2, 8'h01);
    tick(4'b0000, "R5 R8 specific clear high input");
    tick(4'b0000, "R5 no reset without edge");
    // R10: mask toggle re-edges
    wr(2'd0, 8'h02);
    tick(4'b0000, "R10 masked");
    wr(2'd0, 8'h00);
    tick(4'b0000, "R10 unmask write");
    tick(4'b0010, "R10 new edge");
    wr(2'd2, 8'h01);
    devReq[3] = 0;
    tick(4'b0000, "R8 clear ch1");
    // R6: level mode on ch3
    wr(2'd1, 8'h08);
    tick(4'b0000, "R7 mode write");
    devReq[9] = 1;
    tick(4'b1000, "R6 level set");
    devReq[9] = 0;
    tick(4'b1000, "R6 level hold until eoi");
    wr(2'd2, 8'h03);
    tick(4'b0000, "R6 eoi input low clears");
    devReq[10] = 1;
    tick(4'b1000, "R6 level set again");
    wr(2'd2, 8'h03);
    tick(4'b1000, "R6 eoi input high stays");
    devReq[10] = 0;
    tick(4'b1000, "R6 hold");
    wr(2'd2, 8'h03);
    tick(4'b0000, "R6 eoi after drop");
    // R11: edge coinciding with clear on ch0
    devReq[0] = 1;
    tick(4'b0001, "R4 ch0 edge");
    devReq[0] = 0;
    tick(4'b0001, "R4 ch0 hold");
    devReq[0] = 1;
    wr(2'd2, 8'h00);
    tick(4'b0001, "R11 set wins");
    wr(2'd2, 8'h00);
    tick(4'b0000, "R5 clear ch0");
    devReq[0] = 0;
    // R1: shared lines on ch2
    devReq[6] = 1;
    tick(4'b0100, "R1 line6 edge");
    devReq[7] = 1;
    devReq[6] = 0;
    wr(2'd2, 8'h02);
    tick(4'b0000, "R1 eoi ch2");
    tick(4'b0000, "R1 second line no edge");
    devReq[7] = 0;
    tick(4'b0000, "R1 idle");
    // R9: priority between ch1 and ch2
    devReq[3] = 1;
    devReq[6] = 1;
    tick(4'b0110, "R3 two pending");
    wr(2'd2, 8'h80);
    tick(4'b0100, "R9 ch1 first");
    wr(2'd2, 8'h80);
    tick(4'b0000, "R9 ch2 next");
    devReq = '0;
    tick(4'b0000, "R3 irq low");
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule